// File: doc/BRIEF.md
# Write-Only Two-Wire Register Target

This block is the receiving end of a two-wire serial control bus that accepts register writes only. A system clock samples the bus clock and data lines through a short synchronizer, and the block recognises bus START and STOP conditions from the synchronized levels. After a START it collects a device-address byte. It compares the upper five bits against a fixed pattern and the next two bits against a 2-bit strap input, and it requires a write-direction bit.

When the device address matches, the block acknowledges it. It then takes one byte as a register pointer, and every byte after that as write data. Each data byte produces a one-cycle write strobe that carries the current pointer and the byte. The pointer then steps up by one, so a burst of data lands at consecutive registers. The data line is modelled as an enable that pulls the line low. The surrounding bus logic combines that enable with the other drivers.

Top module: `i2c_wr_target`

## Requirements
- R1: The device address byte is acknowledged only when its seven upper bits equal 01111 followed by the two strap bits (strap bit 1 then bit 0) and its least significant bit, the direction bit, is 0; all four strap codes 00, 01, 10 and 11 are honoured.
- R2: A device address byte whose direction bit is 1 is never acknowledged, and no following byte in that transfer is acknowledged or produces a write strobe.
- R3: After a device address mismatch the block neither acknowledges any byte nor produces a write strobe until the next START.
- R4: The byte after an acknowledged device address is acknowledged and loaded as the register pointer; bytes are shifted in most significant bit first, with data sampled while the bus clock is high.
- R5: Each data byte is acknowledged by pulling the data line low during the ninth clock. The block raises a write strobe for exactly one system clock with the register pointer on the address output and the received byte on the data output.
- R6: The register pointer increases by one after each data byte's acknowledge, wrapping from FF to 00, and the strobe for a byte carries the pointer value from before that increment.
- R7: A repeated START (START with no STOP before it) restarts device address reception, and the byte after the new address is taken as a fresh register pointer.
- R8: A STOP at any point returns the block to idle, and bytes clocked after it without a new START are not acknowledged and produce no strobe.
- R9: While reset is asserted and immediately after reset, the data-line pull-down and the write strobe are both inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved bus value) |
| strap_i | input | 2 | Selects the two low device address bits |
| sda_drive_low_o | output | 1 | When 1, the data line is pulled low (acknowledge) |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register pointer; valid as the write address while the strobe is high |
| wr_data_o | output | 8 | Write data; valid while the strobe is high |

## Verification
The bench sweeps every strap code against every strap-field variant in both directions, and also walks a spread of device addresses whose fixed upper bits differ. A comparator that used the wrong bits, or that ignored the direction bit, would acknowledge a foreign or read transfer. A burst starting at FD crosses the FF-to-00 wrap and uses the data bytes 80 and 01. A pointer that incremented before the strobe, or did not wrap, or a shifter with the bit order reversed, would put data at the wrong register or with the wrong value. Other transfers stop before any data byte, restart with a repeated START, or keep clocking after a mismatch or a STOP. A block that kept its previous phase would acknowledge those stray bytes or strobe them into the register file.

// File: rtl/i2c_wr_target.sv
module i2c_wr_target #(
  parameter logic [4:0] ADDR_HI  = 5'b01111,
  parameter int         SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_drive_low_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);

  typedef enum logic [1:0] {PH_IDLE, PH_DEV, PH_REG, PH_DATA} phase_t;

  logic [SYNC_LEN-1:0] scl_sync, sda_sync;
  logic                scl_q, sda_q;
  logic [3:0]          bit_cnt;
  logic                in_ack;
  logic [7:0]          shreg, ptr, data_q;
  logic                drive, stb;
  phase_t              phase;

  wire scl_s    = scl_sync[SYNC_LEN-1];
  wire sda_s    = sda_sync[SYNC_LEN-1];
  wire start_ev = scl_q & scl_s & sda_q & ~sda_s;
  wire stop_ev  = scl_q & scl_s & ~sda_q & sda_s;
  wire scl_rise = ~scl_q & scl_s;
  wire scl_fall = scl_q & ~scl_s;
  wire byte_end = (bit_cnt == 4'd8);
  wire dev_hit  = (shreg[7:1] == {ADDR_HI, strap_i}) && !shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_LEN-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_LEN-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      shreg   <= '0;
      ptr     <= '0;
      data_q  <= '0;
      drive   <= 1'b0;
      stb     <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (start_ev) begin
        phase   <= PH_DEV;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        drive   <= 1'b0;
      end else if (stop_ev) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        drive   <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !byte_end) begin
          shreg   <= {shreg[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall && byte_end) begin
          if (in_ack) begin
            drive   <= 1'b0;
            in_ack  <= 1'b0;
            bit_cnt <= '0;
            case (phase)
              PH_DEV:  phase <= PH_REG;
              PH_REG:  phase <= PH_DATA;
              PH_DATA: ptr   <= ptr + 8'd1;
              default: phase <= PH_IDLE;
            endcase
          end else begin
            case (phase)
              PH_DEV: begin
                if (dev_hit) begin
                  drive  <= 1'b1;
                  in_ack <= 1'b1;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_REG: begin
                ptr    <= shreg;
                drive  <= 1'b1;
                in_ack <= 1'b1;
              end
              PH_DATA: begin
                data_q <= shreg;
                stb    <= 1'b1;
                drive  <= 1'b1;
                in_ack <= 1'b1;
              end
              default: phase <= PH_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign sda_drive_low_o = drive;
  assign wr_stb_o        = stb;
  assign wr_addr_o       = ptr;
  assign wr_data_o       = data_q;

endmodule

// File: rtl/i2c_wr_target_chk.sv
module i2c_wr_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_drive_low_o,
  input logic       wr_stb_o,
  input logic [7:0] wr_addr_o
);

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o); // R5

  AST_STB_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> sda_drive_low_o); // R5

  AST_ACK_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_drive_low_o) || $fell(sda_drive_low_o)) |-> !scl_i); // R5

  AST_PTR_HOLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> $stable(wr_addr_o)); // R6

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> (!sda_drive_low_o && !wr_stb_o)); // R9

endmodule

bind i2c_wr_target i2c_wr_target_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .scl_i(scl_i),
  .sda_drive_low_o(sda_drive_low_o),
  .wr_stb_o(wr_stb_o),
  .wr_addr_o(wr_addr_o)
);

// File: tb/test_i2c_wr_target.sv
module test_i2c_wr_target;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       sda_drive_low_o, wr_stb_o;
  logic [7:0] wr_addr_o, wr_data_o;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_drive_low_o;

  always #10 clk = ~clk;

  i2c_wr_target i_i2c_wr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
    .sda_drive_low_o(sda_drive_low_o), .wr_stb_o(wr_stb_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int n_stb = 0;
  int dbl_stb = 0;
  logic prev_stb = 1'b0;
  logic [7:0] log_a [0:63];
  logic [7:0] log_d [0:63];

  always @(negedge clk) begin
    if (wr_stb_o && prev_stb) dbl_stb++;
    prev_stb = wr_stb_o;
    if (wr_stb_o && n_stb < 64) begin
      log_a[n_stb] = wr_addr_o;
      log_d[n_stb] = wr_data_o;
      n_stb++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10);
    scl_m = 1'b0; tick(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(5);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(5);
      scl_m = 1'b1; tick(10);
      scl_m = 1'b0; tick(5);
    end
    sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(5);
    ack = !sda_bus; tick(5);
    scl_m = 1'b0; tick(5);
  endtask

  function automatic logic [7:0] dev_byte(input logic [1:0] v, input logic rw);
    return {5'b01111, v, rw};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    int base;
    tick(3);
    chk(sda_drive_low_o == 1'b0, "R9 drive in reset", sda_drive_low_o, 0);
    chk(wr_stb_o == 1'b0, "R9 strobe in reset", wr_stb_o, 0);
    rst_n = 1'b1;
    tick(3);
    chk(sda_drive_low_o == 1'b0, "R9 drive after reset", sda_drive_low_o, 0);
    chk(wr_stb_o == 1'b0, "R9 strobe after reset", wr_stb_o, 0);

    // R1 R2: strap code against strap field, both directions
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int v = 0; v < 4; v++) begin
        for (int rw = 0; rw < 2; rw++) begin
          bus_start();
          send_byte(dev_byte(2'(v), 1'(rw)), ack);
          chk(ack == ((v == s) && (rw == 0)), rw ? "R2 read direction" : "R1 address match",
              ack, (v == s) && (rw == 0));
          bus_stop();
        end
      end
    end

    // R1: spread of 7-bit addresses with strap 10
    strap = 2'b10;
    for (int d = 0; d < 128; d += 9) begin
      bus_start();
      send_byte({7'(d), 1'b0}, ack);
      chk(ack == (d == 7'b0111110), "R1 address sweep", ack, d == 7'b0111110);
      bus_stop();
    end
    chk(n_stb == 0, "R1 no strobe during address sweep", n_stb, 0);

    // R4 R5 R6: burst across the pointer wrap, MSB-first data
    strap = 2'b01;
    base = n_stb;
    bus_start();
    send_byte(dev_byte(2'b01, 1'b0), ack);
    chk(ack, "R1 burst device ack", ack, 1);
    send_byte(8'hFD, ack);
    chk(ack, "R4 register byte ack", ack, 1);
    for (int j = 0; j < 4; j++) begin
      send_byte((j == 0) ? 8'h80 : (j == 1) ? 8'h01 : 8'(j * 75), ack);
      chk(ack, "R5 data byte ack", ack, 1);
    end
    bus_stop();
    chk(n_stb - base == 4, "R5 strobe count", n_stb - base, 4);
    for (int j = 0; j < 4; j++) begin
      logic [7:0] ea, ed;
      ea = 8'(8'hFD + j);
      ed = (j == 0) ? 8'h80 : (j == 1) ? 8'h01 : 8'(j * 75);
      chk(log_a[base + j] == ea, "R6 strobe address", log_a[base + j], ea);
      chk(log_d[base + j] == ed, "R4 R5 strobe data", log_d[base + j], ed);
    end
    chk(dbl_stb == 0, "R5 strobe width one cycle", dbl_stb, 0);

    // R3: mismatch then more bytes
    base = n_stb;
    bus_start();
    send_byte(dev_byte(2'b11, 1'b0), ack);
    chk(!ack, "R3 mismatch nack", ack, 0);
    send_byte(8'h20, ack);
    chk(!ack, "R3 following byte nack", ack, 0);
    send_byte(dev_byte(2'b01, 1'b0), ack);
    chk(!ack, "R3 matching value without START nack", ack, 0);
    send_byte(8'h99, ack);
    chk(!ack, "R3 data byte nack", ack, 0);
    bus_stop();
    chk(n_stb == base, "R3 no strobe", n_stb - base, 0);

    // R2: read direction then more bytes
    bus_start();
    send_byte(dev_byte(2'b01, 1'b1), ack);
    chk(!ack, "R2 read nack", ack, 0);
    send_byte(8'h05, ack);
    chk(!ack, "R2 following byte nack", ack, 0);
    send_byte(8'h77, ack);
    chk(!ack, "R2 data byte nack", ack, 0);
    bus_stop();
    chk(n_stb == base, "R2 no strobe", n_stb - base, 0);

    // R7: repeated START
    base = n_stb;
    bus_start();
    send_byte(dev_byte(2'b01, 1'b0), ack);
    send_byte(8'h10, ack);
    send_byte(8'hAA, ack);
    bus_start();
    send_byte(dev_byte(2'b01, 1'b0), ack);
    chk(ack, "R7 address after repeated START", ack, 1);
    send_byte(8'h40, ack);
    chk(ack, "R7 new register byte ack", ack, 1);
    send_byte(8'h55, ack);
    send_byte(8'h66, ack);
    bus_stop();
    chk(n_stb - base == 3, "R7 strobe count", n_stb - base, 3);
    chk(log_a[base] == 8'h10 && log_d[base] == 8'hAA, "R7 first write", log_a[base], 8'h10);
    chk(log_a[base + 1] == 8'h40 && log_d[base + 1] == 8'h55, "R7 restarted pointer",
        log_a[base + 1], 8'h40);
    chk(log_a[base + 2] == 8'h41 && log_d[base + 2] == 8'h66, "R7 R6 increment",
        log_a[base + 2], 8'h41);

    // R8: STOP after register byte, then bytes without START
    base = n_stb;
    bus_start();
    send_byte(dev_byte(2'b01, 1'b0), ack);
    send_byte(8'h30, ack);
    bus_stop();
    scl_m = 1'b0; tick(5);
    send_byte(8'h3C, ack);
    chk(!ack, "R8 byte after STOP nack", ack, 0);
    send_byte(dev_byte(2'b01, 1'b0), ack);
    chk(!ack, "R8 address without START nack", ack, 0);
    send_byte(8'h12, ack);
    chk(!ack, "R8 data without START nack", ack, 0);
    bus_stop();
    chk(n_stb == base, "R8 no strobe after STOP", n_stb - base, 0);

    // R8: STOP in the middle of a burst, then a fresh transfer
    bus_start();
    send_byte(dev_byte(2'b01, 1'b0), ack);
    send_byte(8'h70, ack);
    send_byte(8'hE1, ack);
    bus_stop();
    bus_start();
    send_byte(dev_byte(2'b01, 1'b0), ack);
    send_byte(8'h08, ack);
    send_byte(8'h2B, ack);
    bus_stop();
    chk(n_stb - base == 2, "R8 strobes around STOP", n_stb - base, 2);
    chk(log_a[base] == 8'h70 && log_d[base] == 8'hE1, "R8 write before STOP",
        log_a[base], 8'h70);
    chk(log_a[base + 1] == 8'h08 && log_d[base + 1] == 8'h2B, "R8 write after new START",
        log_a[base + 1], 8'h08);
    chk(dbl_stb == 0, "R5 strobe width overall", dbl_stb, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule